// File: doc/BRIEF.md
# ALU Status Flag Register

This block keeps the sixteen-bit flag word that sits beside an arithmetic unit. Each cycle it may be told which class of operation has just run (add, subtract, logic, single-bit left shift or single-bit right shift), whether that operation was a byte or a word, both operands, the carry-in and the result the unit produced. From these it derives the carry, auxiliary (nibble) carry, parity, zero, sign and overflow status flags and stores them on the next rising clock edge. The result itself is computed elsewhere; this block only judges it.

Beside the six status flags the word holds three control flags: direction, interrupt enable and trap. Software moves direction and interrupt enable with dedicated set and clear strobes, moves the carry with set, clear and complement strobes, and can replace the whole word at once through a load port. The stored word is always visible on a read port, with every bit that carries no flag fixed at zero.

Top module: `flagword_reg`

## Requirements
- R1: While `rst_n` is low, and on the first edge after it rises, the flag word reads 0x0000.
- R2: Bit positions are fixed: carry 0, parity 2, auxiliary 4, zero 6, sign 7, trap 8, interrupt enable 9, direction 10, overflow 11; bits 1, 3, 5 and 12 to 15 always read 0 and a load never sets them.
- R3: On op code 0 (add) the carry flag is the carry out of the top bit of a+b+cin; on op code 1 (subtract) it is the borrow out of a-b-cin. With `wide`=0 only bits 7:0 of the operands count, with `wide`=1 bits 15:0.
- R4: On add and subtract the auxiliary flag is the carry (or borrow) from bit 3 into bit 4; logic and shift operations clear it.
- R5: The sign flag copies the top bit of the result at the selected width, and the zero flag is 1 when the result at that width is zero; for byte operations bits 15:8 of the result are ignored.
- R6: The parity flag is 1 when bits 7:0 of the result hold an even number of ones, for every op class.
- R7: On add and subtract the overflow flag is 1 exactly when the signed result at the selected width does not fit.
- R8: On op code 2 (logic) carry and overflow are cleared while sign, zero and parity are updated.
- R9: On op code 3 (shift left by one) carry takes the top operand bit and overflow is the top result bit XOR that carry; on op code 4 (shift right by one) carry takes operand bit 0 and overflow takes the top operand bit.
- R10: The carry strobes act in the order set, clear, complement, and each overrides both an arithmetic update and a load in the same cycle; complement inverts the value held before the edge.
- R11: Direction and interrupt enable change only through their strobes (set wins over clear) or a load; trap changes only through a load; status updates never touch any of the three.
- R12: A load writes the masked load word and overrides a status update presented in the same cycle.
- R13: With `upd_en` low, or with an op code of 5, 6 or 7, and no strobe or load, the flag word keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset, clears the word |
| upd_en | input | 1 | Apply a status update this cycle |
| op_cls | input | 3 | Operation class: 0 add, 1 subtract, 2 logic, 3 shift left, 4 shift right |
| wide | input | 1 | 0 byte operation, 1 word operation |
| opa | input | 16 | First operand (the shifted value for shifts) |
| opb | input | 16 | Second operand |
| cin | input | 1 | Carry or borrow into add and subtract |
| res | input | 16 | Result produced by the arithmetic unit |
| cf_set | input | 1 | Force carry to 1 |
| cf_clr | input | 1 | Force carry to 0 |
| cf_cmp | input | 1 | Invert carry |
| df_set | input | 1 | Force direction to 1 |
| df_clr | input | 1 | Force direction to 0 |
| if_set | input | 1 | Force interrupt enable to 1 |
| if_clr | input | 1 | Force interrupt enable to 0 |
| wr_en | input | 1 | Load the whole word from `wr_data` |
| wr_data | input | 16 | Word to load |
| flags_q | output | 16 | Stored flag word |

## Verification
Properties watch, on every cycle, that the unused bits stay at zero, that a set or clear carry strobe always wins in the following cycle, that a logic operation leaves carry and overflow clear, that trap moves only on a load, that direction follows its set strobe, and that an idle cycle leaves the word untouched. The exact values of carry, auxiliary, overflow and parity across byte and word widths, including junk in the upper result byte, the complement strobe acting on the old carry, and a load racing an update, are shown only by the bench's scenarios checked against its own integer model.

// File: rtl/flagword_pkg.sv
package flagword_pkg;

  localparam int unsigned FW_WIDTH = 16;

  // Bit positions inside the flag word
  localparam int unsigned FB_C = 0;
  localparam int unsigned FB_P = 2;
  localparam int unsigned FB_A = 4;
  localparam int unsigned FB_Z = 6;
  localparam int unsigned FB_S = 7;
  localparam int unsigned FB_T = 8;
  localparam int unsigned FB_I = 9;
  localparam int unsigned FB_D = 10;
  localparam int unsigned FB_O = 11;

  localparam logic [FW_WIDTH-1:0] FW_MASK =
    FW_WIDTH'((1 << FB_C) | (1 << FB_P) | (1 << FB_A) | (1 << FB_Z) | (1 << FB_S) |
              (1 << FB_T) | (1 << FB_I) | (1 << FB_D) | (1 << FB_O));

  typedef enum logic [2:0] {
    OPC_ADD   = 3'd0,
    OPC_SUB   = 3'd1,
    OPC_LOGIC = 3'd2,
    OPC_SHL   = 3'd3,
    OPC_SHR   = 3'd4
  } opc_e;

  typedef struct packed {
    logic c;
    logic p;
    logic a;
    logic z;
    logic s;
    logic o;
  } stat_t;

  // 1 when the byte holds an even number of ones
  function automatic logic even_ones(input logic [7:0] v);
    logic acc;
    acc = 1'b1;
    for (int k = 0; k < 8; k++) acc = acc ^ v[k];
    return acc;
  endfunction

  // Signed overflow of an add: equal operand signs, result sign differs
  function automatic logic add_ovf(input logic sa, input logic sb, input logic sr);
    return (sa == sb) && (sr != sa);
  endfunction

  // Signed overflow of a subtract: operand signs differ, result sign follows b
  function automatic logic sub_ovf(input logic sa, input logic sb, input logic sr);
    return (sa != sb) && (sr != sa);
  endfunction

endpackage

// File: rtl/flag_calc.sv
module flag_calc
  import flagword_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [2:0]        op_cls,
  input  logic              wide,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              cin,
  input  logic [DATA_W-1:0] res,
  output stat_t             st,
  output logic              op_known,
  output logic              op_logic
);

  localparam int unsigned PAD_W = DATA_W - BYTE_W;

  logic [DATA_W-1:0] a_m, b_m;
  logic [DATA_W:0]   add_ext, sub_ext;
  logic              add_cy, sub_bw;
  logic              a_msb, b_msb, r_msb;
  logic              r_zero;
  logic              nib_cy;

  assign a_m = wide ? opa : {{PAD_W{1'b0}}, opa[BYTE_W-1:0]};
  assign b_m = wide ? opb : {{PAD_W{1'b0}}, opb[BYTE_W-1:0]};

  assign add_ext = {1'b0, a_m} + {1'b0, b_m} + {{DATA_W{1'b0}}, cin};
  assign sub_ext = {1'b0, a_m} - {1'b0, b_m} - {{DATA_W{1'b0}}, cin};

  // Width-selected carry and borrow out of the top bit
  assign add_cy = wide ? add_ext[DATA_W] : add_ext[BYTE_W];
  assign sub_bw = wide ? sub_ext[DATA_W] : sub_ext[BYTE_W];

  assign a_msb  = wide ? opa[DATA_W-1] : opa[BYTE_W-1];
  assign b_msb  = wide ? opb[DATA_W-1] : opb[BYTE_W-1];
  assign r_msb  = wide ? res[DATA_W-1] : res[BYTE_W-1];
  assign r_zero = wide ? (res == '0) : (res[BYTE_W-1:0] == '0);

  // Carry or borrow from bit 3 into bit 4
  assign nib_cy = opa[4] ^ opb[4] ^ res[4];

  always_comb begin
    st       = '0;
    st.p     = even_ones(res[7:0]);
    st.z     = r_zero;
    st.s     = r_msb;
    op_known = 1'b1;
    op_logic = 1'b0;
    case (op_cls)
      OPC_ADD: begin
        st.c = add_cy;
        st.a = nib_cy;
        st.o = add_ovf(a_msb, b_msb, r_msb);
      end
      OPC_SUB: begin
        st.c = sub_bw;
        st.a = nib_cy;
        st.o = sub_ovf(a_msb, b_msb, r_msb);
      end
      OPC_LOGIC: begin
        op_logic = 1'b1;
      end
      OPC_SHL: begin
        st.c = a_msb;
        st.o = r_msb ^ a_msb;
      end
      OPC_SHR: begin
        st.c = opa[0];
        st.o = a_msb;
      end
      default: op_known = 1'b0;
    endcase
  end

endmodule

// File: rtl/flag_store.sv
module flag_store
  import flagword_pkg::*;
#(
  parameter int unsigned FLAG_W = FW_WIDTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_apply,
  input  logic              upd_logic,
  input  stat_t             st,
  input  logic              cf_set,
  input  logic              cf_clr,
  input  logic              cf_cmp,
  input  logic              df_set,
  input  logic              df_clr,
  input  logic              if_set,
  input  logic              if_clr,
  input  logic              wr_en,
  input  logic [FLAG_W-1:0] wr_data,
  output logic [FLAG_W-1:0] flags_q
);

  localparam logic [FLAG_W-1:0] KEEP = FLAG_W'(FW_MASK);

  logic [FLAG_W-1:0] flags_d;
  logic              any_strobe;

  assign any_strobe = cf_set | cf_clr | cf_cmp | df_set | df_clr | if_set | if_clr;

  always_comb begin
    flags_d = flags_q;
    if (wr_en) begin
      flags_d = wr_data & KEEP;
    end else if (upd_apply) begin
      flags_d[FB_C] = st.c;
      flags_d[FB_P] = st.p;
      flags_d[FB_A] = st.a;
      flags_d[FB_Z] = st.z;
      flags_d[FB_S] = st.s;
      flags_d[FB_O] = st.o;
    end
    if (cf_set)      flags_d[FB_C] = 1'b1;
    else if (cf_clr) flags_d[FB_C] = 1'b0;
    else if (cf_cmp) flags_d[FB_C] = ~flags_q[FB_C];
    if (df_set)      flags_d[FB_D] = 1'b1;
    else if (df_clr) flags_d[FB_D] = 1'b0;
    if (if_set)      flags_d[FB_I] = 1'b1;
    else if (if_clr) flags_d[FB_I] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q & ~KEEP) == '0);

  assert_cset_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cf_set |=> flags_q[FB_C]);

  assert_cclr_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cf_clr && !cf_set) |=> !flags_q[FB_C]);

  assert_logic_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_apply && upd_logic && !wr_en && !cf_set && !cf_cmp) |=>
      (!flags_q[FB_C] && !flags_q[FB_O]));

  assert_trap_load_only_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> (flags_q[FB_T] == $past(flags_q[FB_T])));

  assert_dir_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    df_set |=> flags_q[FB_D]);

  assert_idle_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_apply && !wr_en && !any_strobe) |=> $stable(flags_q));

endmodule

// File: rtl/flagword_reg.sv
module flagword_reg
  import flagword_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_en,
  input  logic [2:0]        op_cls,
  input  logic              wide,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic              cin,
  input  logic [DATA_W-1:0] res,
  input  logic              cf_set,
  input  logic              cf_clr,
  input  logic              cf_cmp,
  input  logic              df_set,
  input  logic              df_clr,
  input  logic              if_set,
  input  logic              if_clr,
  input  logic              wr_en,
  input  logic [FW_WIDTH-1:0] wr_data,
  output logic [FW_WIDTH-1:0] flags_q
);

  stat_t st;
  logic  op_known;
  logic  op_logic;
  logic  upd_apply;

  flag_calc #(
    .DATA_W (DATA_W),
    .BYTE_W (BYTE_W)
  ) u_calc (
    .op_cls   (op_cls),
    .wide     (wide),
    .opa      (opa),
    .opb      (opb),
    .cin      (cin),
    .res      (res),
    .st       (st),
    .op_known (op_known),
    .op_logic (op_logic)
  );

  assign upd_apply = upd_en & op_known;

  flag_store #(
    .FLAG_W (FW_WIDTH)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_apply (upd_apply),
    .upd_logic (op_logic),
    .st        (st),
    .cf_set    (cf_set),
    .cf_clr    (cf_clr),
    .cf_cmp    (cf_cmp),
    .df_set    (df_set),
    .df_clr    (df_clr),
    .if_set    (if_set),
    .if_clr    (if_clr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .flags_q   (flags_q)
  );

endmodule

// File: tb/flagword_reg_bench.sv
`timescale 1ns/1ps
module flagword_reg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_en = 1'b0;
  logic [2:0]  op_cls = 3'd0;
  logic        wide = 1'b0;
  logic [15:0] opa = '0, opb = '0, res = '0;
  logic        cin = 1'b0;
  logic        cf_set = 0, cf_clr = 0, cf_cmp = 0, df_set = 0, df_clr = 0, if_set = 0, if_clr = 0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] flags_q;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct {
    logic [15:0] exp;
    string       tag;
  } sb_item_t;

  sb_item_t    sbq[$];
  logic [15:0] mdl = 16'h0000;

  always #2.5 clk = ~clk;

  flagword_reg u_flagword_reg (
    .clk (clk), .rst_n (rst_n), .upd_en (upd_en), .op_cls (op_cls), .wide (wide),
    .opa (opa), .opb (opb), .cin (cin), .res (res),
    .cf_set (cf_set), .cf_clr (cf_clr), .cf_cmp (cf_cmp),
    .df_set (df_set), .df_clr (df_clr), .if_set (if_set), .if_clr (if_clr),
    .wr_en (wr_en), .wr_data (wr_data), .flags_q (flags_q)
  );

  // Integer model of the flag rules
  function automatic logic [15:0] predict(
    input logic [15:0] cur, input bit upd, input int op, input bit wd,
    input int a, input int b, input int ci, input int r,
    input bit [6:0] stb, input bit ld, input logic [15:0] ldw);
    int w, lim, am, bm, rm, sa, sb, ss, ones;
    bit c, af, o, s, z, p;
    logic [15:0] n;
    w = wd ? 16 : 8;
    lim = 1 << w;
    am = a % lim; bm = b % lim; rm = r % lim;
    sa = (am >= lim/2) ? am - lim : am;
    sb = (bm >= lim/2) ? bm - lim : bm;
    c = 0; af = 0; o = 0;
    if (op == 0) begin
      c  = (am + bm + ci) >= lim;
      af = ((am % 16) + (bm % 16) + ci) > 15;
      ss = sa + sb + ci;
      o  = (ss > lim/2 - 1) || (ss < -(lim/2));
    end else if (op == 1) begin
      c  = (am - bm - ci) < 0;
      af = ((am % 16) - (bm % 16) - ci) < 0;
      ss = sa - sb - ci;
      o  = (ss > lim/2 - 1) || (ss < -(lim/2));
    end else if (op == 3) begin
      c = ((am >> (w-1)) & 1) == 1;
      o = c ^ (((rm >> (w-1)) & 1) == 1);
    end else if (op == 4) begin
      c = (am & 1) == 1;
      o = ((am >> (w-1)) & 1) == 1;
    end
    s = ((rm >> (w-1)) & 1) == 1;
    z = (rm == 0);
    ones = 0;
    for (int k = 0; k < 8; k++) ones += (r >> k) & 1;
    p = (ones % 2) == 0;
    n = cur;
    if (ld) n = ldw & 16'h0FD5;
    else if (upd && op <= 4) begin
      n[0] = c; n[2] = p; n[4] = af; n[6] = z; n[7] = s; n[11] = o;
    end
    if (stb[6])      n[0] = 1'b1;
    else if (stb[5]) n[0] = 1'b0;
    else if (stb[4]) n[0] = ~cur[0];
    if (stb[3])      n[10] = 1'b1;
    else if (stb[2]) n[10] = 1'b0;
    if (stb[1])      n[9] = 1'b1;
    else if (stb[0]) n[9] = 1'b0;
    return n;
  endfunction

  // Driver: stb = {cf_set, cf_clr, cf_cmp, df_set, df_clr, if_set, if_clr}
  task automatic apply(input string tag, input bit upd, input int op, input bit wd,
                       input int a, input int b, input int ci, input int r,
                       input bit [6:0] stb, input bit ld, input logic [15:0] ldw);
    sb_item_t it;
    @(negedge clk);
    upd_en = upd; op_cls = 3'(op); wide = wd;
    opa = 16'(a); opb = 16'(b); cin = ci[0]; res = 16'(r);
    {cf_set, cf_clr, cf_cmp, df_set, df_clr, if_set, if_clr} = stb;
    wr_en = ld; wr_data = ldw;
    mdl = predict(mdl, upd, op, wd, a, b, ci, r, stb, ld, ldw);
    it.exp = mdl; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic idle();
    @(negedge clk);
    upd_en = 0; wr_en = 0;
    {cf_set, cf_clr, cf_cmp, df_set, df_clr, if_set, if_clr} = '0;
  endtask

  // Monitor: compares one expected item per cycle after each capture edge
  initial begin
    sb_item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        it = sbq.pop_front();
        checks++;
        if (flags_q !== it.exp) begin
          fails++;
          $display("FAIL %s: flags actual %h expected %h", it.tag, flags_q, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    checks++;
    if (flags_q !== 16'h0000) begin
      fails++;
      $display("FAIL R1 in reset: actual %h expected 0000", flags_q);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    checks++;
    if (flags_q !== 16'h0000) begin
      fails++;
      $display("FAIL R1 after reset: actual %h expected 0000", flags_q);
    end

    apply("R3 R4 R5 R7 add8 7F+01",      1, 0, 0, 'h7F,   'h01,   0, 'h80,   7'b0, 0, 0);
    apply("R3 R6 add8 FF+01 carry zero", 1, 0, 0, 'hFF,   'h01,   0, 'h00,   7'b0, 0, 0);
    apply("R3 add16 FFFF+0+cin",         1, 0, 1, 'hFFFF, 'h0000, 1, 'h0000, 7'b0, 0, 0);
    apply("R6 add16 1234+4321",          1, 0, 1, 'h1234, 'h4321, 0, 'h5555, 7'b0, 0, 0);
    apply("R3 R4 sub8 00-01 borrow",     1, 1, 0, 'h00,   'h01,   0, 'hFF,   7'b0, 0, 0);
    apply("R7 sub16 8000-0001",          1, 1, 1, 'h8000, 'h0001, 0, 'h7FFF, 7'b0, 0, 0);
    apply("R3 sub16 5-3-cin",            1, 1, 1, 'h0005, 'h0003, 1, 'h0001, 7'b0, 0, 0);
    apply("R10 carry set alone",         0, 0, 0, 0, 0, 0, 0, 7'b1000000, 0, 0);
    apply("R8 logic16 clears C O",       1, 2, 1, 'hFFFF, 'h8001, 0, 'h8001, 7'b0, 0, 0);
    apply("R9 shl8 81",                  1, 3, 0, 'h81,   0,      0, 'h02,   7'b0, 0, 0);
    apply("R9 shr16 8001",               1, 4, 1, 'h8001, 0,      0, 'h4000, 7'b0, 0, 0);
    apply("R5 byte add upper junk",      1, 0, 0, 'hAB10, 'hCDF0, 0, 'h3400, 7'b0, 0, 0);
    apply("R13 unknown op code 7",       1, 7, 1, 'h0001, 'h0001, 0, 'h0000, 7'b0, 0, 0);
    apply("R13 upd_en low",              0, 0, 1, 'hFFFF, 'h0001, 0, 'h0000, 7'b0, 0, 0);
    apply("R2 R12 load all ones masked", 0, 0, 0, 0, 0, 0, 0, 7'b0, 1, 16'hFFFF);
    apply("R10 carry complement",        0, 0, 0, 0, 0, 0, 0, 7'b0010000, 0, 0);
    apply("R10 clear beats add carry",   1, 0, 0, 'hFF,   'h01,   0, 'h00,   7'b0100000, 0, 0);
    apply("R10 set beats add no carry",  1, 0, 0, 'h01,   'h01,   0, 'h02,   7'b1000000, 0, 0);
    apply("R10 set beats clear",         0, 0, 0, 0, 0, 0, 0, 7'b1100000, 0, 0);
    apply("R11 clear D and I",           0, 0, 0, 0, 0, 0, 0, 7'b0000101, 0, 0);
    apply("R11 D set beats clear, I set",0, 0, 0, 0, 0, 0, 0, 7'b0001110, 0, 0);
    apply("R11 update keeps D I T",      1, 1, 1, 'h0001, 'h0002, 0, 'hFFFF, 7'b0, 0, 0);
    apply("R12 load beats update",       1, 0, 1, 'hFFFF, 'h0001, 0, 'h0000, 7'b0, 1, 16'h0000);
    apply("R10 R12 carry set over load", 0, 0, 0, 0, 0, 0, 0, 7'b1000000, 1, 16'h0100);
    apply("R10 complement of held one",  1, 0, 0, 'h01,   'h01,   0, 'h02,   7'b0010000, 0, 0);
    idle();
    repeat (4) @(posedge clk);
    #1;
    checks++;
    if (flags_q !== mdl) begin
      fails++;
      $display("FAIL R13 idle hold: actual %h expected %h", flags_q, mdl);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule